// File: doc/BRIEF.md
# Eight-Channel Repeat-Qualified Record Packer

The block sits behind a bank of eight demodulated receive channels. Each channel delivers whole words (an address byte plus a three-bit payload) already deserialized, marked by a one-cycle strobe. A channel is trusted only once it has seen the same word, addressed to itself, three times in a row. At that point its qualified line goes high.

When a qualified line rises, the block turns the channel number into a three-bit binary code using a plain OR network with one term per output bit. It puts that code next to the payload in one byte and issues a single-cycle write strobe towards a downstream FIFO. If several channels qualify in the same cycle, their records leave one per cycle in ascending channel order.

Top module: `rxp_word_packer`

## Requirements
- R1: While reset is low and right after it, `rec_wr` is 0, `rec_byte` is 0x00 and every `chan_valid` bit is 0.
- R2: `chan_valid[i]` goes high in the cycle after the third consecutive strobed word on channel i with address equal to channel i's fixed address (`CH_ADDR[8i+7:8i]`) and identical payload. After only two such words it stays low.
- R3: A strobed word with the right address but a payload different from the held one restarts the run at one, with the new payload held. `chan_valid[i]` drops, and two more identical words are then needed.
- R4: A strobed word whose address differs from the channel's fixed address clears the run to zero and drops `chan_valid[i]`. Three fresh matching words are then needed.
- R5: A record has the payload in bits 2:0 and the channel code in bits 5:3, where channel 0 is 000 and channel 7 is 111. Bits 7:6 are 0.
- R6: Each rising edge of a `chan_valid` bit gives exactly one `rec_wr` pulse. With no other write outstanding, that pulse comes in the cycle after the rise. Further identical words while the line stays high produce no writes.
- R7: When several `chan_valid` bits rise in the same cycle, their records are written on consecutive cycles, lowest channel first.
- R8: Cycles with a channel's strobe low leave that channel's run and `chan_valid` bit unchanged, so the repeated words need not be back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_stb | input | 8 | Per-channel word-present strobe |
| word_addr | input | 64 | Per-channel received address, channel i at bits 8i+7:8i |
| word_data | input | 24 | Per-channel received payload, channel i at bits 3i+2:3i |
| chan_valid | output | 8 | Per-channel qualified line |
| rec_wr | output | 1 | One-cycle write strobe to the FIFO |
| rec_byte | output | 8 | Packed record, held between writes |

## Verification
The hardest case to reach is several channels qualifying on exactly the same clock edge, since arbitration only matters then. The driver task strobes three channels together with different payloads on three consecutive word slots, so their third words land on one edge. The scoreboard then expects three records on three back-to-back cycles, in ascending channel order. Each expected record carries the exact cycle in which it must appear, so a late, early, duplicated or reordered write is reported.

// File: rtl/rxp_pkg.sv
// Package: shared types for the record packer.
// Assumes a run never needs more than three matching words.
package rxp_pkg;
    typedef enum logic [1:0] {
        RUN_NONE = 2'd0,
        RUN_ONE  = 2'd1,
        RUN_TWO  = 2'd2,
        RUN_FULL = 2'd3
    } run_cnt_e;
endpackage

// File: rtl/rxp_chan_qual.sv
// Per-channel qualifier: counts consecutive identical words that carry
// this channel's address. It qualifies the channel once three are seen.
// Assumes word_stb is a single-cycle mark per received word.
module rxp_chan_qual
    import rxp_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 3,
    parameter logic [AW-1:0] MY_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_stb,
    input  logic [AW-1:0] word_addr,
    input  logic [DW-1:0] word_data,
    output logic          qual,
    output logic [DW-1:0] ref_data
);
    run_cnt_e run_q;

    // Track the current run length and the payload it repeats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= RUN_NONE;
            ref_data <= '0;
        end else if (word_stb) begin
            if (word_addr != MY_ADDR) begin
                run_q <= RUN_NONE;
            end else if (run_q == RUN_NONE || word_data != ref_data) begin
                run_q    <= RUN_ONE;
                ref_data <= word_data;
            end else if (run_q != RUN_FULL) begin
                run_q <= run_cnt_e'(run_q + 2'd1);
            end
        end
    end

    // Qualified once the run is complete.
    always_comb qual = (run_q == RUN_FULL);
endmodule

// File: rtl/rxp_arbiter.sv
// Rise arbiter: turns rising edges of the qualified lines into one-hot
// grants, serving one channel per cycle from the lowest index. It
// freezes each channel's payload at its rise.
// Assumes a channel does not rise again before its grant is served.
module rxp_arbiter #(
    parameter int NCH = 8,
    parameter int DW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    qual,
    input  logic [NCH*DW-1:0] ref_data,
    output logic [NCH-1:0]    grant,
    output logic [NCH*DW-1:0] cand_data
);
    logic [NCH-1:0]    qual_prev;
    logic [NCH-1:0]    pending;
    logic [NCH*DW-1:0] held;
    logic [NCH-1:0]    rise;
    logic [NCH-1:0]    req;

    // Detect new qualifications and pick the lowest requesting channel.
    always_comb begin
        rise  = qual & ~qual_prev;
        req   = pending | rise;
        grant = req & (~req + {{(NCH-1){1'b0}}, 1'b1});
    end

    // Remember previous qualification and un-served requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_prev <= '0;
            pending   <= '0;
        end else begin
            qual_prev <= qual;
            pending   <= req & ~grant;
        end
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        // Freeze the payload at the moment the channel qualifies.
        always_ff @(posedge clk) begin
            if (!rst_n) held[gi*DW +: DW] <= '0;
            else if (rise[gi]) held[gi*DW +: DW] <= ref_data[gi*DW +: DW];
        end

        // Present the fresh payload on the rise cycle, the frozen one later.
        always_comb cand_data[gi*DW +: DW] =
            rise[gi] ? ref_data[gi*DW +: DW] : held[gi*DW +: DW];
    end
endmodule

// File: rtl/rxp_onehot_enc.sv
// Priority-free encoder: each output bit is the OR of the one-hot lines
// whose index has that bit set. Assumes at most one input bit is high.
module rxp_onehot_enc #(
    parameter int NCH = 8,
    parameter int IDW = 3
) (
    input  logic [NCH-1:0] onehot,
    output logic [IDW-1:0] idx
);
    for (genvar gb = 0; gb < IDW; gb++) begin : g_bit
        logic [NCH-1:0] term;
        for (genvar gi = 0; gi < NCH; gi++) begin : g_term
            if (((gi >> gb) % 2) == 1) begin : g_on
                assign term[gi] = onehot[gi];
            end else begin : g_off
                assign term[gi] = 1'b0;
            end
        end
        // One OR term per output bit.
        assign idx[gb] = |term;
    end
endmodule

// File: rtl/rxp_word_packer.sv
// Top: eight repeat-qualified channels, a rise arbiter, an OR encoder
// and the record register that drives the FIFO write port.
// Assumes REC_W >= DW + IDW + 1 and word inputs already deserialized.
module rxp_word_packer #(
    parameter int NCH   = 8,
    parameter int AW    = 8,
    parameter int DW    = 3,
    parameter int REC_W = 8,
    parameter logic [NCH*AW-1:0] CH_ADDR = 64'hF7E6_D5C4_B3A2_9180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    word_stb,
    input  logic [NCH*AW-1:0] word_addr,
    input  logic [NCH*DW-1:0] word_data,
    output logic [NCH-1:0]    chan_valid,
    output logic              rec_wr,
    output logic [REC_W-1:0]  rec_byte
);
    localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PAD = REC_W - IDW - DW;

    logic [NCH*DW-1:0] ref_data;
    logic [NCH*DW-1:0] cand_data;
    logic [NCH-1:0]    grant;
    logic [IDW-1:0]    gnt_idx;
    logic [DW-1:0]     gnt_data;
    logic [REC_W-1:0]  rec_next;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        rxp_chan_qual #(
            .AW(AW), .DW(DW), .MY_ADDR(CH_ADDR[gi*AW +: AW])
        ) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .word_stb (word_stb[gi]),
            .word_addr(word_addr[gi*AW +: AW]),
            .word_data(word_data[gi*DW +: DW]),
            .qual     (chan_valid[gi]),
            .ref_data (ref_data[gi*DW +: DW])
        );
    end

    rxp_arbiter #(.NCH(NCH), .DW(DW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (chan_valid),
        .ref_data (ref_data),
        .grant    (grant),
        .cand_data(cand_data)
    );

    rxp_onehot_enc #(.NCH(NCH), .IDW(IDW)) u_enc (
        .onehot(grant),
        .idx   (gnt_idx)
    );

    // AND-OR select of the granted channel's payload.
    always_comb begin
        gnt_data = '0;
        for (int i = 0; i < NCH; i++) begin
            gnt_data = gnt_data | (cand_data[i*DW +: DW] & {DW{grant[i]}});
        end
        rec_next = {{PAD{1'b0}}, gnt_idx, gnt_data};
    end

    // Register the record and its one-cycle write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_wr   <= 1'b0;
            rec_byte <= '0;
        end else begin
            rec_wr <= |grant;
            if (|grant) rec_byte <= rec_next;
        end
    end
endmodule

// File: rtl/rxp_word_packer_chk.sv
// Checker: port-level properties of the record packer, bound to the top.
module rxp_word_packer_chk #(
    parameter int NCH   = 8,
    parameter int AW    = 8,
    parameter int REC_W = 8,
    parameter logic [NCH*AW-1:0] CH_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    word_stb,
    input logic [NCH*AW-1:0] word_addr,
    input logic [NCH-1:0]    chan_valid,
    input logic              rec_wr,
    input logic [REC_W-1:0]  rec_byte
);
    assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_wr |-> (rec_byte[REC_W-1:6] == '0));

    assert_rise_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(chan_valid & ~$past(chan_valid))) |=> rec_wr);

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        assert_rise_after_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chan_valid[gi]) |-> $past(word_stb[gi]));

        assert_bad_addr_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (word_stb[gi] && word_addr[gi*AW +: AW] != CH_ADDR[gi*AW +: AW])
            |=> !chan_valid[gi]);

        assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !word_stb[gi] |=> $stable(chan_valid[gi]));
    end
endmodule

bind rxp_word_packer rxp_word_packer_chk #(
    .NCH(NCH), .AW(AW), .REC_W(REC_W), .CH_ADDR(CH_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_stb  (word_stb),
    .word_addr (word_addr),
    .chan_valid(chan_valid),
    .rec_wr    (rec_wr),
    .rec_byte  (rec_byte)
);

// File: tb/rxp_word_packer_bench.sv
module rxp_word_packer_bench;
    typedef struct packed {
        int unsigned cyc;
        logic [7:0]  b;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  word_stb = '0;
    logic [63:0] word_addr = '0;
    logic [23:0] word_data = '0;
    logic [7:0]  chan_valid;
    logic        rec_wr;
    logic [7:0]  rec_byte;

    int unsigned cyc = 0;
    int checks = 0;
    int bad = 0;
    exp_t q[$];
    int   m_cnt[8];
    logic [2:0] m_ref[8];

    rxp_word_packer u_rxp_word_packer (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_addr(word_addr),
        .word_data(word_data), .chan_valid(chan_valid), .rec_wr(rec_wr),
        .rec_byte(rec_byte)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] addr_of(input int ch);
        return 8'h80 + 8'(8'h11 * ch);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: present one word slot, update the reference model, queue records.
    task automatic send(input logic [7:0] mask, input logic [23:0] dat, input logic [7:0] badaddr);
        int unsigned e;
        int rank;
        @(negedge clk);
        for (int ch = 0; ch < 8; ch++) begin
            word_stb[ch] = mask[ch];
            word_addr[ch*8 +: 8] = addr_of(ch) ^ (badaddr[ch] ? 8'h01 : 8'h00);
            word_data[ch*3 +: 3] = dat[ch*3 +: 3];
        end
        @(posedge clk);
        #1;
        e = cyc;
        rank = 0;
        for (int ch = 0; ch < 8; ch++) begin
            if (mask[ch]) begin
                logic was;
                exp_t it;
                was = (m_cnt[ch] == 3);
                if (badaddr[ch]) m_cnt[ch] = 0;
                else if (m_cnt[ch] == 0 || dat[ch*3 +: 3] != m_ref[ch]) begin
                    m_cnt[ch] = 1;
                    m_ref[ch] = dat[ch*3 +: 3];
                end else if (m_cnt[ch] < 3) m_cnt[ch]++;
                if (!was && m_cnt[ch] == 3) begin
                    it.cyc = e + 1 + rank;
                    it.b = {2'b00, 3'(ch), m_ref[ch]};
                    q.push_back(it);
                    rank++;
                end
            end
        end
        @(negedge clk);
        word_stb = '0;
    endtask

    // Monitor: every write must match the next expected record and cycle (R5 R6 R7).
    always @(negedge clk) begin
        if (rst_n && rec_wr) begin
            if (q.size() == 0) begin
                checks++; bad++;
                $display("FAIL R6 unexpected write actual=%0h expected=none", rec_byte);
            end else begin
                exp_t it;
                it = q.pop_front();
                chk("R5 record byte", 32'(rec_byte), 32'(it.b));
                chk("R7 write cycle", cyc, it.cyc);
            end
        end
    end

    task automatic drain();
        repeat (12) @(negedge clk);
        chk("R6 all records written", q.size(), 0);
    endtask

    task automatic run_all();
        for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_ref[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rec_wr in reset", 32'(rec_wr), 0);
        chk("R1 rec_byte in reset", 32'(rec_byte), 0);
        chk("R1 chan_valid in reset", 32'(chan_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rec_wr after reset", 32'(rec_wr), 0);

        // R2: two words are not enough, the third qualifies channel 2.
        send(8'h04, 24'(5) << 6, 8'h00);
        send(8'h04, 24'(5) << 6, 8'h00);
        chk("R2 two words not valid", 32'(chan_valid[2]), 0);
        send(8'h04, 24'(5) << 6, 8'h00);
        chk("R2 third word valid", 32'(chan_valid[2]), 1);
        // R6: a fourth identical word keeps valid high and writes nothing new.
        send(8'h04, 24'(5) << 6, 8'h00);
        chk("R6 still valid", 32'(chan_valid[2]), 1);
        drain();

        // R3: different payload restarts the run at one.
        send(8'h04, 24'(3) << 6, 8'h00);
        chk("R3 new payload drops valid", 32'(chan_valid[2]), 0);
        send(8'h04, 24'(3) << 6, 8'h00);
        chk("R3 second of new run", 32'(chan_valid[2]), 0);
        send(8'h04, 24'(3) << 6, 8'h00);
        chk("R3 third of new run valid", 32'(chan_valid[2]), 1);
        drain();

        // R4: wrong address clears the run.
        send(8'h04, 24'(3) << 6, 8'h04);
        chk("R4 bad address drops valid", 32'(chan_valid[2]), 0);
        send(8'h04, 24'(3) << 6, 8'h00);
        send(8'h04, 24'(3) << 6, 8'h00);
        chk("R4 two after clear not valid", 32'(chan_valid[2]), 0);
        send(8'h04, 24'(3) << 6, 8'h00);
        chk("R4 three after clear valid", 32'(chan_valid[2]), 1);
        drain();

        // R8: idle gaps between repeats keep the run.
        send(8'h80, 24'(6) << 21, 8'h00);
        repeat (5) @(negedge clk);
        send(8'h80, 24'(6) << 21, 8'h00);
        repeat (7) @(negedge clk);
        chk("R8 idle holds low", 32'(chan_valid[7]), 0);
        send(8'h80, 24'(6) << 21, 8'h00);
        chk("R8 gapped run valid", 32'(chan_valid[7]), 1);
        drain();

        // R7: channels 1, 4, 6 qualify on one edge; written 1, 4, 6.
        for (int k = 0; k < 3; k++)
            send(8'h52, (24'(6) << 3) | (24'(2) << 12) | (24'(1) << 18), 8'h00);
        chk("R7 three valid together", 32'(chan_valid & 8'h52), 32'h52);
        drain();

        // R5: channel 0 record with payload 7 gives 0x07.
        send(8'h01, 24'(7), 8'h00);
        send(8'h01, 24'(7), 8'h00);
        send(8'h01, 24'(7), 8'h00);
        drain();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                checks++; bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule